// File: doc/BRIEF.md
# Coprocessor Reset and Initialization Controller

This block puts the architectural state of an arithmetic coprocessor into a known state. Two sources can start it. The first is the hardware power-on/system reset, which asserts asynchronously and is released through a two-stage synchronizer. The second is a software command that restores a null state frame. Either source aborts whatever the operation sequencer is doing. Each then runs the same initialization pass. The pass writes a quiet NaN into each of the eight 80-bit extended-precision data registers, one register per clock. It clears the control and status registers together with the first data write.

The host processor also has a reset strobe, driven by its reset instruction. That strobe resets the rest of the system, and the coprocessor counts as part of the host's internal state. The controller takes the strobe as an input and gives it no effect. Software reaches the reset state through the null-restore command instead. A hardware reset is still required once at power-up, because the flops are in an unknown state before it.

A null-restore command that arrives while a pass is running is remembered, not lost. Several such commands merge into one. The remembered command starts a fresh pass straight after the last write of the current pass.

Top module: `cp_init_ctrl`

## Requirements
- R1: While `hw_rst` is high, `seq_abort` and `busy` are 1 and `fpr_we` and `csr_clr` are 0. This holds from the moment `hw_rst` rises, before any clock edge.
- R2: After `hw_rst` falls, `seq_abort` and `busy` stay 1 and `fpr_we` stays 0 through the cycles that follow the first and second rising edges. The first register write appears in the cycle after the third rising edge, and `seq_abort` is 0 in that cycle.
- R3: An initialization pass is eight consecutive cycles with `fpr_we`=1. `fpr_idx` counts 0,1,...,7. `fpr_wdata` is 80'h7FFF_FFFF_FFFF_FFFF_FFFF in every one of these cycles: bit 79 (sign) is 0, bits 78:64 (exponent) are all ones, bit 63 (integer bit) is 1, and bits 62:0 (fraction) are all ones, so the fraction MSB is set. `csr_clr` is 1 only in the cycle with `fpr_idx`=0.
- R4: `busy` is 1 through the last write cycle of a pass. When no command is waiting, `busy`, `fpr_we` and `seq_abort` are all 0 in the following cycle.
- R5: A `null_restore` sampled high while the block is idle starts a pass in the next cycle. `seq_abort` is 1 in the first cycle of that pass and 0 in the other seven.
- R6: A `null_restore` sampled while a pass is running, including in its last write cycle, is deferred. Several deferred requests give exactly one extra pass. That pass follows the last write directly with no idle cycle, and `seq_abort` is 1 in its first cycle.
- R7: `host_rst` has no effect. With it high, the outputs are the same as with it low, both while idle and during a pass.
- R8: A `null_restore` sampled while the synchronized hardware reset is still active is dropped. Only the single pass that follows the hardware reset runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst | input | 1 | Power-on/system reset, active high, asynchronous assert |
| host_rst | input | 1 | Reset strobe from the host's reset instruction (ignored) |
| null_restore | input | 1 | Software null-frame restore command, sampled each clock |
| busy | output | 1 | Reset or initialization in progress |
| seq_abort | output | 1 | Forces the operation sequencer to abort and return to idle |
| fpr_we | output | 1 | Data register write enable |
| fpr_idx | output | 3 | Data register index being written |
| fpr_wdata | output | 80 | Value written (extended-format quiet NaN) |
| csr_clr | output | 1 | Clears the control and status registers to zero |

## Verification
A software restore request can land in the same cycle as the last register write of a running pass. In that case the block must finish the pass and start another with no gap. Requests can also arrive mid-pass and merge with a later one. The tests drive a request on the final write cycle, and separately two requests in the middle of a pass. In each case the bench requires the second pass to start on the very next cycle with the abort raised, and then expects a clean idle with no third pass. The host reset strobe is also driven in the same cycle as a restore request, and that pass is judged unchanged.

// File: rtl/cp_init_pkg.sv
`timescale 1ns/1ps
package cp_init_pkg;

    localparam int EXT_W  = 80;
    localparam int EXP_W  = 15;
    localparam int FRAC_W = 63;

    typedef struct packed {
        logic              sign;
        logic [EXP_W-1:0]  exponent;
        logic              int_bit;
        logic [FRAC_W-1:0] fraction;
    } ext_fp_t;

    typedef enum logic [1:0] {
        ST_START = 2'd0,
        ST_INIT  = 2'd1,
        ST_IDLE  = 2'd2
    } init_state_t;

    function automatic ext_fp_t quiet_nan();
        ext_fp_t v;
        v.sign     = 1'b0;
        v.exponent = '1;
        v.int_bit  = 1'b1;
        v.fraction = '1;
        return v;
    endfunction

endpackage

// File: rtl/cp_rst_sync.sv
`timescale 1ns/1ps
module cp_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_in,
    output logic rst_out
);
    logic [STAGES-1:0] shreg;

    always_ff @(posedge clk or posedge rst_in) begin
        if (rst_in) shreg <= '1;
        else        shreg <= {shreg[STAGES-2:0], 1'b0};
    end

    assign rst_out = shreg[STAGES-1];
endmodule

// File: rtl/cp_init_seq.sv
`timescale 1ns/1ps
module cp_init_seq
    import cp_init_pkg::*;
#(
    parameter int NUM_REGS = 8,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             rst_sync,
    input  logic             req,
    output logic             active,
    output logic [IDX_W-1:0] cnt,
    output logic             busy,
    output logic             abort
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(NUM_REGS - 1);

    init_state_t state;
    logic        pend;
    logic        abort_q;

    always_ff @(posedge clk) begin
        if (rst_sync) begin
            state   <= ST_START;
            cnt     <= '0;
            pend    <= 1'b0;
            abort_q <= 1'b0;
        end else begin
            abort_q <= 1'b0;
            unique case (state)
                ST_START: begin
                    state <= ST_INIT;
                    cnt   <= '0;
                    if (req) pend <= 1'b1;
                end
                ST_INIT: begin
                    if (cnt == LAST) begin
                        if (req || pend) begin
                            cnt     <= '0;
                            pend    <= 1'b0;
                            abort_q <= 1'b1;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end else begin
                        cnt <= cnt + 1'b1;
                        if (req) pend <= 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (req) begin
                        state   <= ST_INIT;
                        cnt     <= '0;
                        abort_q <= 1'b1;
                    end
                end
                default: state <= ST_START;
            endcase
        end
    end

    assign active = (state == ST_INIT) && !rst_sync;
    assign busy   = rst_sync || (state != ST_IDLE);
    assign abort  = rst_sync || (state == ST_START) || abort_q;

    AST_ABORT_FIRST: assert property (@(posedge clk) disable iff (rst_sync)
        abort_q |-> (state == ST_INIT && cnt == '0)); // R5

    AST_IDX_STEP: assert property (@(posedge clk) disable iff (rst_sync)
        (state == ST_INIT && cnt != LAST) |=> (state == ST_INIT && cnt == $past(cnt) + 1'b1)); // R3

    AST_END_IDLE: assert property (@(posedge clk) disable iff (rst_sync)
        (state == ST_INIT && cnt == LAST && !req && !pend) |=> (state == ST_IDLE)); // R4

    AST_DEFER: assert property (@(posedge clk) disable iff (rst_sync)
        (state == ST_INIT && req) |=> (pend || (abort_q && cnt == '0))); // R6
endmodule

// File: rtl/cp_init_wport.sv
`timescale 1ns/1ps
module cp_init_wport
    import cp_init_pkg::*;
#(
    parameter int IDX_W = 3
) (
    input  logic             active,
    input  logic [IDX_W-1:0] cnt,
    output logic             we,
    output logic [IDX_W-1:0] idx,
    output logic [EXT_W-1:0] wdata,
    output logic             csr_clr
);
    ext_fp_t nan_val;

    always_comb begin
        nan_val = quiet_nan();
        we      = active;
        idx     = cnt;
        wdata   = nan_val;
        csr_clr = active && (cnt == '0);
    end
endmodule

// File: rtl/cp_init_ctrl.sv
`timescale 1ns/1ps
module cp_init_ctrl
    import cp_init_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2,
    localparam int IDX_W = $clog2(NUM_REGS)
) (
    input  logic             clk,
    input  logic             hw_rst,
    input  logic             host_rst,
    input  logic             null_restore,
    output logic             busy,
    output logic             seq_abort,
    output logic             fpr_we,
    output logic [IDX_W-1:0] fpr_idx,
    output logic [EXT_W-1:0] fpr_wdata,
    output logic             csr_clr
);
    logic             rst_sync;
    logic             active;
    logic [IDX_W-1:0] cnt;

    cp_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_in  (hw_rst),
        .rst_out (rst_sync)
    );

    cp_init_seq #(.NUM_REGS(NUM_REGS)) u_seq (
        .clk      (clk),
        .rst_sync (rst_sync),
        .req      (null_restore),
        .active   (active),
        .cnt      (cnt),
        .busy     (busy),
        .abort    (seq_abort)
    );

    cp_init_wport #(.IDX_W(IDX_W)) u_wport (
        .active  (active),
        .cnt     (cnt),
        .we      (fpr_we),
        .idx     (fpr_idx),
        .wdata   (fpr_wdata),
        .csr_clr (csr_clr)
    );

    AST_WE_BUSY: assert property (@(posedge clk) disable iff (rst_sync)
        fpr_we |-> busy); // R4

    AST_HOST_NOEFFECT: assert property (@(posedge clk) disable iff (rst_sync)
        (host_rst && !busy && !null_restore) |=> !busy); // R7

    AST_RESET_NO_WRITE: assert property (@(posedge clk)
        rst_sync |-> (!fpr_we && seq_abort && busy)); // R1
endmodule

// File: tb/cp_init_ctrl_tb_top.sv
`timescale 1ns/1ps
module cp_init_ctrl_tb_top;
    localparam int NREG = 8;
    localparam logic [79:0] QNAN = {1'b0, {15{1'b1}}, 1'b1, {63{1'b1}}};

    logic        clk = 1'b0;
    logic        hw_rst = 1'b0;
    logic        host_rst = 1'b0;
    logic        null_restore = 1'b0;
    logic        busy, seq_abort, fpr_we, csr_clr;
    logic [2:0]  fpr_idx;
    logic [79:0] fpr_wdata;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    cp_init_ctrl dut_i (
        .clk          (clk),
        .hw_rst       (hw_rst),
        .host_rst     (host_rst),
        .null_restore (null_restore),
        .busy         (busy),
        .seq_abort    (seq_abort),
        .fpr_we       (fpr_we),
        .fpr_idx      (fpr_idx),
        .fpr_wdata    (fpr_wdata),
        .csr_clr      (csr_clr)
    );

    task automatic chk(input string tag, input string what, input logic [79:0] act, input logic [79:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    task automatic chk_held(input string tag);
        chk(tag, "busy", 80'(busy), 80'd1);
        chk(tag, "seq_abort", 80'(seq_abort), 80'd1);
        chk(tag, "fpr_we", 80'(fpr_we), 80'd0);
        chk(tag, "csr_clr", 80'(csr_clr), 80'd0);
    endtask

    task automatic chk_idle(input string tag);
        chk(tag, "busy idle", 80'(busy), 80'd0);
        chk(tag, "we idle", 80'(fpr_we), 80'd0);
        chk(tag, "abort idle", 80'(seq_abort), 80'd0);
    endtask

    // Positioned at the negedge of the first write cycle; ends one cycle past the last write.
    task automatic run_init(input string tag, input bit first_abort);
        for (int i = 0; i < NREG; i++) begin
            chk(tag, "we", 80'(fpr_we), 80'd1);
            chk(tag, "idx", 80'(fpr_idx), 80'(i));
            chk("R3", "wdata", fpr_wdata, QNAN);
            chk("R3", "csr_clr", 80'(csr_clr), 80'(i == 0));
            chk("R4", "busy", 80'(busy), 80'd1);
            chk(tag, "abort", 80'(seq_abort), 80'(first_abort && i == 0));
            @(negedge clk);
        end
    endtask

    task automatic release_and_init(input string tag);
        hw_rst = 1'b0;
        @(negedge clk);
        chk_held("R2");
        @(negedge clk);
        chk_held("R2");
        @(negedge clk);
        run_init(tag, 1'b0);
        chk_idle("R4");
    endtask

    task automatic t_power_on();
        #1 hw_rst = 1'b1;
        #1 chk_held("R1");
        repeat (3) @(negedge clk);
        chk_held("R1");
        release_and_init("R3");
    endtask

    task automatic t_null_idle();
        @(negedge clk);
        chk_idle("R5");
        null_restore = 1'b1;
        @(negedge clk);
        null_restore = 1'b0;
        run_init("R5", 1'b1);
        chk_idle("R5");
    endtask

    task automatic t_defer_mid();
        null_restore = 1'b1;
        @(negedge clk);
        null_restore = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            chk("R6", "idx first pass", 80'(fpr_idx), 80'(i));
            chk("R6", "busy first pass", 80'(busy), 80'd1);
            null_restore = (i == 2 || i == 4);
            @(negedge clk);
        end
        null_restore = 1'b0;
        run_init("R6", 1'b1);
        chk_idle("R6");
        @(negedge clk);
        chk_idle("R6");
    endtask

    task automatic t_defer_last();
        null_restore = 1'b1;
        @(negedge clk);
        null_restore = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            chk("R6", "idx before tail", 80'(fpr_idx), 80'(i));
            null_restore = (i == NREG - 1);
            @(negedge clk);
        end
        null_restore = 1'b0;
        run_init("R6", 1'b1);
        chk_idle("R6");
    endtask

    task automatic t_host_ignored();
        host_rst = 1'b1;
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk_idle("R7");
        end
        null_restore = 1'b1;
        @(negedge clk);
        null_restore = 1'b0;
        run_init("R7", 1'b1);
        chk_idle("R7");
        host_rst = 1'b0;
        @(negedge clk);
        chk_idle("R7");
    endtask

    task automatic t_null_in_reset();
        hw_rst = 1'b1;
        null_restore = 1'b1;
        @(negedge clk);
        null_restore = 1'b0;
        chk_held("R8");
        @(negedge clk);
        release_and_init("R8");
        @(negedge clk);
        chk_idle("R8");
        @(negedge clk);
        chk_idle("R8");
    endtask

    task automatic t_reset_midpass();
        null_restore = 1'b1;
        @(negedge clk);
        null_restore = 1'b0;
        repeat (3) @(negedge clk);
        chk("R1", "mid-pass idx", 80'(fpr_idx), 80'd3);
        #3 hw_rst = 1'b1;
        #1 chk_held("R1");
        @(negedge clk);
        chk_held("R1");
        release_and_init("R3");
    endtask

    initial begin
        t_power_on();
        t_null_idle();
        t_defer_mid();
        t_defer_last();
        t_host_ignored();
        t_null_in_reset();
        t_reset_midpass();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule